// File: doc/BRIEF.md
# Fuse Controller with Keyed Indirect Access

This block sits in front of a small one-time-programmable bit array and makes it reachable over a plain 32-bit register bus. The array is modelled as registers whose reset contents come from a seed parameter. Each bit can only be set and never cleared, so programming ORs new ones into a word.

Software reaches the array in two ways. The first is a direct read-only window, where word `i` is visible at window base plus `4*i`. The second is an indirect path through a control register. Software writes a byte offset, an unlock byte and either a read or a program strobe, then polls until the strobe drops. It then collects the result from a data register. Program data comes from a staging register. Every indirect operation runs for a fixed number of cycles. During that time the control register refuses new writes.

Bus reads are combinational from `addr_i`. A write takes effect at the rising clock edge on which `req_i` and `we_i` are both high.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset, the control register (0x40), the result register (0x60) and the staging register (0x50) all read zero. Window word `i` reads `SEED ^ (i * 32'h01020408)`. Unmapped addresses read zero.
- R2: The control word has the byte offset in [23:16], the unlock byte in [15:8], the read strobe in bit 1 and the program strobe in bit 0. A write with unlock byte 0xAC and bit 1 set, made while idle, sets the read strobe. The strobe reads 1 for exactly OP_CYCLES cycles after the accepting edge and then clears by itself.
- R3: When a read completes, register 0x60 holds the fuse word at index `offset[7:2]`. The two low offset bits are ignored. Byte 4i+k of the array sits in bits [8k+7:8k] of word i.
- R4: A program operation ORs into the addressed word the staging value captured at the accepting edge. Writes to 0x50 made after that edge do not change the result.
- R5: No fuse bit ever goes from 1 to 0. Programming with a zero staging value leaves the word unchanged.
- R6: A control write whose unlock byte is not 0xAC is ignored entirely. The control readback, the result register and the array stay unchanged, and no operation starts.
- R7: Control writes made while a strobe is set are ignored. This includes a write in the cycle whose closing edge completes the operation.
- R8: If both strobe bits are written together, only the read is performed and the program strobe stays clear.
- R9: An offset at or beyond 4*WORDS bytes gives a read result of zero and programs nothing.
- R10: Address 0x200 + 4*i reads word i. Window addresses past the array depth read zero, and the low two address bits are ignored. Writes to the window and to 0x60 have no effect.
- R11: A window read of a word in the cycle that completes a program of that word returns the old value. The new value is visible from the next cycle.
- R12: Register 0x50 reads back the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Write enable for the access |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |

## Verification
Two functions meet in one cycle: completion of a queued operation, and a bus access that touches the same state. The bench provokes this by counting OP_CYCLES-1 cycles from the accepting edge. In that last busy cycle it does two things, each in a separate run. In one run it reads the window word being programmed, which must return the old value, and the new value must appear on the next cycle. In the other run it writes a fresh control command, which must be dropped, so that the control register shows idle with the earlier offset still in place. Random mixes of reads, programs, bad-key writes and window reads are judged against a bench-side copy of the array that ORs each accepted program in.

// File: rtl/fuse_ctrl_pkg.sv
package fuse_ctrl_pkg;
  localparam logic [7:0] UNLOCK_KEY = 8'hAC;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_READ = 2'd1,
    OP_PROG = 2'd2
  } op_e;

  function automatic logic [31:0] init_word(input logic [31:0] seed, input int idx);
    return seed ^ (32'(idx) * 32'h0102_0408);
  endfunction
endpackage

// File: rtl/fuse_array.sv
module fuse_array
  import fuse_ctrl_pkg::*;
#(
  parameter int          WORDS = 16,
  parameter logic [31:0] SEED  = 32'h5A3C_0000,
  localparam int         IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prog_en_i,
  input  logic [IDX_W-1:0] prog_idx_i,
  input  logic [31:0]      prog_bits_i,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [31:0]      rd_a_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [31:0]      rd_b_o
);
  logic [31:0] cell_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                        cell_q[g] <= init_word(SEED, g);
      else if (prog_en_i && prog_idx_i == IDX_W'(g))      cell_q[g] <= cell_q[g] | prog_bits_i;
    end

    // fuse bits are one-way
    assert_bits_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cell_q[g] & $past(cell_q[g])) == $past(cell_q[g])));
  end

  assign rd_a_o = (int'(rd_a_idx_i) < WORDS) ? cell_q[rd_a_idx_i] : '0;
  assign rd_b_o = (int'(rd_b_idx_i) < WORDS) ? cell_q[rd_b_idx_i] : '0;
endmodule

// File: rtl/fuse_seq.sv
module fuse_seq
  import fuse_ctrl_pkg::*;
#(
  parameter int  WORDS     = 16,
  parameter int  OP_CYCLES = 8,
  localparam int IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int CNT_W     = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [7:0]       cmd_off_i,
  input  logic [7:0]       cmd_key_i,
  input  logic             cmd_rd_i,
  input  logic             cmd_pg_i,
  input  logic [31:0]      stage_i,
  input  logic [31:0]      arr_word_i,
  output logic [31:0]      ctrl_o,
  output logic [31:0]      result_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] arr_idx_o,
  output logic             prog_en_o,
  output logic [31:0]      prog_bits_o
);
  op_e              op_q;
  logic [7:0]       off_q, key_q;
  logic [CNT_W-1:0] cnt_q;
  logic [31:0]      pbits_q, result_q;
  logic             accept, done, in_range;

  assign accept   = cmd_we_i && (op_q == OP_IDLE) && (cmd_key_i == UNLOCK_KEY);
  assign done     = (op_q != OP_IDLE) && (cnt_q == '0);
  assign in_range = int'(off_q[7:2]) < WORDS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_IDLE;
      off_q    <= '0;
      key_q    <= '0;
      cnt_q    <= '0;
      pbits_q  <= '0;
      result_q <= '0;
    end else if (accept) begin
      off_q   <= cmd_off_i;
      key_q   <= cmd_key_i;
      pbits_q <= stage_i;
      cnt_q   <= CNT_W'(OP_CYCLES - 1);
      if (cmd_rd_i)      op_q <= OP_READ;   // read wins over program
      else if (cmd_pg_i) op_q <= OP_PROG;
    end else if (done) begin
      op_q <= OP_IDLE;
      if (op_q == OP_READ) result_q <= in_range ? arr_word_i : '0;
    end else if (op_q != OP_IDLE) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o      = (op_q != OP_IDLE);
  assign arr_idx_o   = off_q[IDX_W+1:2];
  assign prog_en_o   = done && (op_q == OP_PROG) && in_range;
  assign prog_bits_o = pbits_q;
  assign result_o    = result_q;
  assign ctrl_o      = {8'h00, off_q, key_q, 6'h00, op_q == OP_READ, op_q == OP_PROG};

  assert_bad_key_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && op_q == OP_IDLE && cmd_key_i != UNLOCK_KEY) |=> ($stable(ctrl_o) && $stable(result_o)));

  assert_busy_write_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && op_q != OP_IDLE) |=> ($stable(off_q) && $stable(key_q)));

  assert_read_priority_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && cmd_rd_i && cmd_pg_i) |=> (ctrl_o[1] && !ctrl_o[0]));

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(cnt_q) < OP_CYCLES));

  assert_no_prog_out_of_range_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && int'(off_q[7:2]) >= WORDS) |=> $stable(result_o) || (result_o == '0));
endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
  import fuse_ctrl_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          WORDS     = 16,
  parameter int          OP_CYCLES = 8,
  parameter logic [31:0] SEED      = 32'h5A3C_0000,
  localparam int         IDX_W     = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'('h040);
  localparam logic [ADDR_W-1:0] STAGE_ADDR = ADDR_W'('h050);
  localparam logic [ADDR_W-1:0] RES_ADDR   = ADDR_W'('h060);
  localparam logic [ADDR_W-1:0] WIN_BASE   = ADDR_W'('h200);

  logic              ctrl_we, stage_we, busy, prog_en;
  logic [31:0]       stage_q, ctrl_word, result, prog_bits, win_word, seq_word;
  logic [IDX_W-1:0]  seq_idx;
  logic [ADDR_W-1:0] win_index;
  logic              win_hit, win_in;

  assign ctrl_we  = req_i && we_i && (addr_i == CTRL_ADDR);
  assign stage_we = req_i && we_i && (addr_i == STAGE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       stage_q <= '0;
    else if (stage_we) stage_q <= wdata_i;
  end

  fuse_seq #(.WORDS(WORDS), .OP_CYCLES(OP_CYCLES)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_we_i    (ctrl_we),
    .cmd_off_i   (wdata_i[23:16]),
    .cmd_key_i   (wdata_i[15:8]),
    .cmd_rd_i    (wdata_i[1]),
    .cmd_pg_i    (wdata_i[0]),
    .stage_i     (stage_q),
    .arr_word_i  (seq_word),
    .ctrl_o      (ctrl_word),
    .result_o    (result),
    .busy_o      (busy),
    .arr_idx_o   (seq_idx),
    .prog_en_o   (prog_en),
    .prog_bits_o (prog_bits)
  );

  assign win_hit   = addr_i >= WIN_BASE;
  assign win_index = (addr_i - WIN_BASE) >> 2;
  assign win_in    = win_hit && (int'(win_index) < WORDS);

  fuse_array #(.WORDS(WORDS), .SEED(SEED)) u_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .prog_en_i   (prog_en),
    .prog_idx_i  (seq_idx),
    .prog_bits_i (prog_bits),
    .rd_a_idx_i  (win_index[IDX_W-1:0]),
    .rd_a_o      (win_word),
    .rd_b_idx_i  (seq_idx),
    .rd_b_o      (seq_word)
  );

  always_comb begin
    rdata_o = '0;
    if (win_in)                    rdata_o = win_word;
    else if (addr_i == CTRL_ADDR)  rdata_o = ctrl_word;
    else if (addr_i == STAGE_ADDR) rdata_o = stage_q;
    else if (addr_i == RES_ADDR)   rdata_o = result;
  end

  assert_rd_strobe_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we && !busy && wdata_i[15:8] == UNLOCK_KEY && wdata_i[1]) |=> (busy && ctrl_word[1]));

  assert_stage_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_we |=> $stable(stage_q));
endmodule

// File: tb/fuse_ctrl_tb.sv
module fuse_ctrl_tb;
  localparam int          AW    = 12;
  localparam int          WORDS = 16;
  localparam int          OPC   = 8;
  localparam logic [31:0] SEED  = 32'h5A3C_0000;
  localparam logic [AW-1:0] A_CTRL = 12'h040, A_STG = 12'h050, A_RES = 12'h060, A_WIN = 12'h200;

  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m [WORDS];

  always #4 clk = ~clk;

  fuse_ctrl #(.ADDR_W(AW), .WORDS(WORDS), .OP_CYCLES(OPC), .SEED(SEED)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata));

  function automatic logic [31:0] img(input int i);
    logic [31:0] acc = SEED;
    for (int b = 0; b < i; b++) acc = acc ^ (32'(b) * 32'h0102_0408) ^ (32'(b + 1) * 32'h0102_0408);
    return acc;
  endfunction

  function automatic logic [31:0] cw(input logic [7:0] off, input logic [7:0] key, input logic rd, input logic pg);
    return {8'h00, off, key, 6'h00, rd, pg};
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] off);
    return (int'(off[7:2]) < WORDS) ? m[off[7:2]] : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [AW-1:0] a, output logic [31:0] v);
    addr = a; #1 v = rdata;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); peek(a, v);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 100; k++) begin
      peek(A_CTRL, v);
      if (v[1:0] == 2'b00) return;
      @(negedge clk);
    end
    check("R2 strobe never cleared", v, 32'h0);
  endtask

  task automatic prot_read(input logic [7:0] off, input string tag);
    logic [31:0] v;
    wr(A_CTRL, cw(off, 8'hAC, 1, 0)); wait_idle();
    rd(A_RES, v); check(tag, v, exp_rd(off));
  endtask

  task automatic prot_prog(input logic [7:0] off, input logic [31:0] s);
    wr(A_STG, s); wr(A_CTRL, cw(off, 8'hAC, 0, 1)); wait_idle();
    if (int'(off[7:2]) < WORDS) m[off[7:2]] = m[off[7:2]] | s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    void'($urandom(32'h0000_1234));
    for (int i = 0; i < WORDS; i++) m[i] = img(i);
    repeat (3) @(negedge clk); rst_n = 1;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rd(A_RES, v);  check("R1 result", v, 0);
    rd(A_STG, v);  check("R1 stage", v, 0);
    rd(12'h010, v); check("R1 unmapped", v, 0);
    for (int i = 0; i < WORDS; i++) begin
      rd(A_WIN + AW'(4 * i), v); check("R1 image", v, m[i]);
    end

    // R12 stage readback
    wr(A_STG, 32'hDEAD_BEEF); rd(A_STG, v); check("R12 stage", v, 32'hDEAD_BEEF);

    // R2 exact strobe width, R3 low offset bits ignored
    wr(A_CTRL, cw(8'h0E, 8'hAC, 1, 0));
    peek(A_CTRL, v); check("R2 strobe set", v, cw(8'h0E, 8'hAC, 1, 0));
    repeat (OPC - 1) @(negedge clk);
    peek(A_CTRL, v); check("R2 strobe still set", {30'h0, v[1:0]}, 32'h2);
    @(negedge clk);
    peek(A_CTRL, v); check("R2 strobe cleared", {30'h0, v[1:0]}, 32'h0);
    rd(A_RES, v); check("R3 read word 3", v, m[3]);

    // R6 bad key ignored entirely
    rd(A_CTRL, v2);
    wr(A_CTRL, cw(8'h04, 8'h55, 1, 1));
    peek(A_CTRL, v); check("R6 ctrl unchanged", v, v2);
    rd(A_RES, v); check("R6 result unchanged", v, m[3]);
    rd(A_WIN + 12'h004, v); check("R6 array unchanged", v, m[1]);

    // R4 staging captured at accept
    wr(A_STG, 32'h0000_F00F);
    wr(A_CTRL, cw(8'h08, 8'hAC, 0, 1));
    wr(A_STG, 32'hFFFF_FFFF);
    wait_idle();
    m[2] = m[2] | 32'h0000_F00F;
    rd(A_WIN + 12'h008, v); check("R4 program OR", v, m[2]);

    // R5 zero program keeps word
    prot_prog(8'h08, 32'h0);
    rd(A_WIN + 12'h008, v); check("R5 no clear", v, m[2]);

    // R8 read wins
    wr(A_STG, 32'hFFFF_FFFF);
    wr(A_CTRL, cw(8'h14, 8'hAC, 1, 1));
    peek(A_CTRL, v); check("R8 only read strobe", {30'h0, v[1:0]}, 32'h2);
    wait_idle();
    rd(A_RES, v); check("R8 read result", v, m[5]);
    rd(A_WIN + 12'h014, v); check("R8 no program", v, m[5]);

    // R9 out of range
    prot_read(8'(4 * WORDS), "R9 oor read");
    prot_prog(8'(4 * WORDS + 4), 32'hFFFF_FFFF);
    for (int i = 0; i < WORDS; i++) begin
      rd(A_WIN + AW'(4 * i), v); check("R9 oor program none", v, m[i]);
    end

    // R7 write while busy
    wr(A_STG, 32'h0F00_0000);
    wr(A_CTRL, cw(8'h18, 8'hAC, 0, 1));
    wr(A_CTRL, cw(8'h1C, 8'hAC, 1, 0));
    peek(A_CTRL, v); check("R7 busy write ignored", v, cw(8'h18, 8'hAC, 0, 1));
    wait_idle(); m[6] = m[6] | 32'h0F00_0000;
    rd(A_WIN + 12'h018, v); check("R7 program done", v, m[6]);

    // R7 write in completion cycle
    wr(A_CTRL, cw(8'h20, 8'hAC, 1, 0));
    repeat (OPC - 1) @(negedge clk);
    req = 1; we = 1; addr = A_CTRL; wdata = cw(8'h24, 8'hAC, 1, 0);
    @(negedge clk); req = 0; we = 0;
    peek(A_CTRL, v); check("R7 completion-cycle write", v, cw(8'h20, 8'hAC, 0, 0));

    // R11 same-cycle window read during completion
    wr(A_STG, 32'h0000_00F0);
    wr(A_CTRL, cw(8'h28, 8'hAC, 0, 1));
    repeat (OPC - 1) @(negedge clk);
    peek(A_WIN + 12'h028, v); check("R11 old value", v, m[10]);
    m[10] = m[10] | 32'h0000_00F0;
    @(negedge clk);
    peek(A_WIN + 12'h028, v); check("R11 new value", v, m[10]);

    // R10 window details
    rd(A_WIN + 12'h007, v); check("R10 low bits ignored", v, m[1]);
    rd(A_WIN + AW'(4 * WORDS), v); check("R10 past depth", v, 0);
    wr(A_WIN + 12'h00C, 32'hFFFF_FFFF);
    rd(A_WIN + 12'h00C, v); check("R10 window write ignored", v, m[3]);
    rd(A_RES, v2); wr(A_RES, 32'h1234_5678);
    rd(A_RES, v); check("R10 result write ignored", v, v2);

    // random mix
    for (int it = 0; it < 200; it++) begin
      int sel = $urandom_range(0, 3);
      logic [7:0] off = 8'($urandom_range(0, 4 * WORDS + 7));
      case (sel)
        0: prot_read(off, "R3 random read");
        1: begin
          prot_prog(off, $urandom() & $urandom() & $urandom());
          rd(A_WIN + AW'({off[7:2], 2'b00}), v);
          check("R4 random program", v, exp_rd(off));
        end
        2: begin
          rd(A_CTRL, v2);
          wr(A_CTRL, cw(off, 8'($urandom_range(0, 171)), 1, 1));
          peek(A_CTRL, v); check("R6 random bad key", v, v2);
        end
        default: begin
          rd(A_WIN + AW'(off), v); check("R10 random window", v, exp_rd(off));
        end
      endcase
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule